// File: doc/BRIEF.md
# Open-Row Tracking Command Sequencer

This block sits between a simple user command port and the command pins of a DDR SDRAM. It takes one user READ or WRITE at a time, together with a packed address that names a rank, a row, an internal bank and a column. It keeps a table of open rows for every rank and bank pair. From that table it picks the shortest legal pin sequence. A row hit needs only the column command. A closed bank gets an ACTIVATE first. A bank that holds a different row is precharged, then activated, then accessed.

Every gap between SDRAM commands is held to its configured minimum by small down-counters: ACTIVATE to column, precharge period, activate-to-precharge, same-bank activate cycle, cross-bank activate spacing, write recovery and write-to-read turnaround. A `busy` output tells the user when the next command may be presented. A refresh request, taken only while idle, closes every bank with a single precharge-all and reports completion with a one-cycle pulse. Data movement, strobes, the refresh command itself and power-up initialisation belong to other blocks.

Top module: `rowseq_top`

## Requirements
- R1: `cmd` codes are 3'b001 READ and 3'b010 WRITE; they are accepted only on a rising edge where `busy` is low and `ref_req` is low, and `busy` is high in the following cycle. Code 3'b000 and codes 3'b011 to 3'b111 are not accepted: `busy` stays low and the pins stay at NOP.
- R2: After the column command, `busy` stays high for exactly BURST_LEN/2 cycles counted from the cycle that shows the column command, then falls.
- R3: `addr` is packed, most significant first, as rank (RANK_W bits), row (ROW_W), bank (BANK_W), column (COL_W). The chip select of the addressed rank alone is driven low (sd_cs_n bit r low for rank r). ACTIVATE drives the row on `sd_a`; column commands drive column bits 0 to 9 on `sd_a[9:0]`, column bits 10 and up on `sd_a[11]` upward, with `sd_a[10]` low. `sd_ba` carries the bank.
- R4: Pin encoding on {sd_ras_n, sd_cas_n, sd_we_n}: ACTIVATE 011, READ 101, WRITE 100, PRECHARGE 010, NOP 111. On NOP every chip select is high; after reset the pins show NOP and `busy` and `ref_done` are low.
- R5: A row hit issues only the column command; with no delay window pending it appears in the cycle after the acceptance edge.
- R6: A closed bank gets ACTIVATE then the column command, at least T_RCD cycles apart.
- R7: A row miss gets PRECHARGE (sd_a[10] low), ACTIVATE, column command. PRECHARGE to ACTIVATE of that bank is at least T_RP cycles; ACTIVATE to PRECHARGE of one bank is at least T_RAS cycles.
- R8: Two ACTIVATEs to the same rank and bank are at least T_RC cycles apart; any two ACTIVATEs are at least T_RRD cycles apart.
- R9: A write ends BURST_LEN/2 cycles after its column command. PRECHARGE of that bank follows the end by at least T_WR cycles; any READ follows it by at least T_WTR cycles.
- R10: Open rows are tracked separately for each rank and bank pair: activating bank b of one rank neither closes nor replaces the open row of bank b in another rank.
- R11: A refresh request taken while idle issues one PRECHARGE with `sd_a[10]` high and every chip select low, then raises `ref_done` for one cycle exactly T_RP cycles later; afterwards every bank counts as closed. A request and a command on the same edge: the request wins.
- R12: A `ref_req` pulse that arrives while `busy` is high has no effect: no precharge-all and no `ref_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; everything is on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd | input | 3 | User command code |
| addr | input | RANK_W+ROW_W+BANK_W+COL_W | Packed rank, row, bank, column |
| ref_req | input | 1 | Request to close all banks for refresh |
| busy | output | 1 | High while a command or refresh is in progress |
| ref_done | output | 1 | One-cycle pulse when the refresh precharge period has elapsed |
| sd_cs_n | output | 2**RANK_W | Active-low chip select per rank |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BANK_W | Internal bank select |
| sd_a | output | ROW_W | Row or column address |

## Verification
The hardest case is a row miss on a bank whose activate-to-precharge or write-recovery window is still open, which needs the bank to have been activated or written only a few cycles earlier. The random stimulus draws rows from a set of three over eight rank and bank slots, so misses and hits on recently touched banks arrive back to back. A refresh pulse dropped into the middle of a long miss sequence covers the busy-time request. Every pin command is checked against the bench's own timestamps for every delay rule.

// File: rtl/rowseq_pkg.sv
`timescale 1ns/1ps
// Shared codes for the open-row sequencer.
package rowseq_pkg;
    // user command codes
    localparam logic [2:0] UC_READ  = 3'b001;
    localparam logic [2:0] UC_WRITE = 3'b010;

    // pin codes on {ras_n, cas_n, we_n}
    localparam logic [2:0] PIN_ACT = 3'b011;
    localparam logic [2:0] PIN_RD  = 3'b101;
    localparam logic [2:0] PIN_WR  = 3'b100;
    localparam logic [2:0] PIN_PRE = 3'b010;
    localparam logic [2:0] PIN_NOP = 3'b111;

    typedef enum logic [2:0] {
        S_IDLE, S_WORK, S_DATA, S_RPRE, S_RWAIT
    } seq_state_e;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/rowseq_dcnt.sv
`timescale 1ns/1ps
// Loadable down-counter that stops at zero.
// Assumes: a load value of N makes zero visible N edges later.
module rowseq_dcnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] value,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    // load or count toward zero
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (load)         cnt_q <= value;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/rowseq_table.sv
`timescale 1ns/1ps
// Open-row table: one valid bit and one row per rank/bank slot.
// Assumes: at most one of set/clr per cycle; clr_all overrides both.
module rowseq_table #(
    parameter int NB    = 8,
    parameter int IDX_W = 3,
    parameter int ROW_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    input  logic             set,
    input  logic [ROW_W-1:0] set_row,
    input  logic             clr,
    input  logic             clr_all,
    output logic             open_v,
    output logic [ROW_W-1:0] open_row
);
    logic             v_q [NB];
    logic [ROW_W-1:0] r_q [NB];

    for (genvar g = 0; g < NB; g++) begin : g_slot
        // update one slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_q[g] <= 1'b0;
                r_q[g] <= '0;
            end else if (clr_all || (clr && idx == IDX_W'(g))) begin
                v_q[g] <= 1'b0;
            end else if (set && idx == IDX_W'(g)) begin
                v_q[g] <= 1'b1;
                r_q[g] <= set_row;
            end
        end

        assert_clr_all_R11: assert property (@(posedge clk) disable iff (!rst_n)
            clr_all |=> !v_q[g]);
    end

    assign open_v   = v_q[idx];
    assign open_row = r_q[idx];

    assert_one_update_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(set && clr));
endmodule

// File: rtl/rowseq_timers.sv
`timescale 1ns/1ps
// Delay windows between SDRAM commands.
// Per slot: activate-to-precharge, activate cycle, write recovery.
// Shared: activate-to-column, precharge period, activate spacing,
// write-to-read. A delay D loaded at edge t clears at edge t+D.
module rowseq_timers #(
    parameter int NB        = 8,
    parameter int IDX_W     = 3,
    parameter int BURST_LEN = 4,
    parameter int T_RCD     = 2,
    parameter int T_RP      = 2,
    parameter int T_RAS     = 6,
    parameter int T_RC      = 8,
    parameter int T_RRD     = 2,
    parameter int T_WR      = 2,
    parameter int T_WTR     = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    input  logic             act_ld,
    input  logic             pre_ld,
    input  logic             preall_ld,
    input  logic             rd_ld,
    input  logic             wr_ld,
    output logic             ok_act,
    output logic             ok_pre,
    output logic             ok_preall,
    output logic             ok_rd,
    output logic             ok_wr,
    output logic             trp_z
);
    import rowseq_pkg::*;

    localparam int HALF  = BURST_LEN / 2;
    localparam int LMAX  = max2(max2(max2(T_RC, T_RAS), max2(HALF + T_WR, HALF + T_WTR)),
                                max2(T_RCD, max2(T_RP, T_RRD)));
    localparam int CNT_W = $clog2(LMAX + 1);

    localparam logic [CNT_W-1:0] L_RCD = CNT_W'(T_RCD - 1);
    localparam logic [CNT_W-1:0] L_RP  = CNT_W'(T_RP - 1);
    localparam logic [CNT_W-1:0] L_RAS = CNT_W'(T_RAS - 1);
    localparam logic [CNT_W-1:0] L_RC  = CNT_W'(T_RC - 1);
    localparam logic [CNT_W-1:0] L_RRD = CNT_W'(T_RRD - 1);
    localparam logic [CNT_W-1:0] L_WR  = CNT_W'(HALF + T_WR - 1);
    localparam logic [CNT_W-1:0] L_WTR = CNT_W'(HALF + T_WTR - 1);

    logic ras_z [NB];
    logic rc_z  [NB];
    logic wr_z  [NB];
    logic trcd_z, rrd_z, wtr_z;

    for (genvar g = 0; g < NB; g++) begin : g_bank
        logic hit_g;
        assign hit_g = (idx == IDX_W'(g));
        rowseq_dcnt #(.W(CNT_W)) u_ras (.clk(clk), .rst_n(rst_n), .load(act_ld && hit_g),
                                        .value(L_RAS), .zero(ras_z[g]));
        rowseq_dcnt #(.W(CNT_W)) u_rc  (.clk(clk), .rst_n(rst_n), .load(act_ld && hit_g),
                                        .value(L_RC), .zero(rc_z[g]));
        rowseq_dcnt #(.W(CNT_W)) u_wr  (.clk(clk), .rst_n(rst_n), .load(wr_ld && hit_g),
                                        .value(L_WR), .zero(wr_z[g]));
    end

    rowseq_dcnt #(.W(CNT_W)) u_rcd (.clk(clk), .rst_n(rst_n), .load(act_ld),
                                    .value(L_RCD), .zero(trcd_z));
    rowseq_dcnt #(.W(CNT_W)) u_rp  (.clk(clk), .rst_n(rst_n), .load(pre_ld || preall_ld),
                                    .value(L_RP), .zero(trp_z));
    rowseq_dcnt #(.W(CNT_W)) u_rrd (.clk(clk), .rst_n(rst_n), .load(act_ld),
                                    .value(L_RRD), .zero(rrd_z));
    rowseq_dcnt #(.W(CNT_W)) u_wtr (.clk(clk), .rst_n(rst_n), .load(wr_ld),
                                    .value(L_WTR), .zero(wtr_z));

    // precharge-all waits for every slot to be closable
    always_comb begin
        ok_preall = 1'b1;
        for (int i = 0; i < NB; i++) ok_preall = ok_preall && ras_z[i] && wr_z[i];
    end

    assign ok_act = rc_z[idx] && rrd_z && trp_z;
    assign ok_pre = ras_z[idx] && wr_z[idx];
    assign ok_rd  = trcd_z && wtr_z;
    assign ok_wr  = trcd_z;

    assert_act_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        act_ld |-> (rc_z[idx] && rrd_z && trp_z));
    assert_pre_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pre_ld |-> (ras_z[idx] && wr_z[idx]));
    assert_col_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ld || wr_ld) |-> trcd_z);
    assert_wtr_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ld |-> wtr_z);
endmodule

// File: rtl/rowseq_top.sv
`timescale 1ns/1ps
// Open-row tracking command sequencer.
// Takes one READ/WRITE at a time, chooses hit / activate / precharge
// path from the open-row table and drives registered SDRAM command pins.
// Assumes: ROW_W >= COL_W + 1 when COL_W > 10 (column skips A10);
// every delay parameter is at least 1.
module rowseq_top #(
    parameter int RANK_W    = 1,
    parameter int ROW_W     = 12,
    parameter int BANK_W    = 2,
    parameter int COL_W     = 11,
    parameter int BURST_LEN = 4,
    parameter int T_RCD     = 2,
    parameter int T_RP      = 2,
    parameter int T_RAS     = 6,
    parameter int T_RC      = 8,
    parameter int T_RRD     = 2,
    parameter int T_WR      = 2,
    parameter int T_WTR     = 1
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [2:0]                            cmd,
    input  logic [RANK_W+ROW_W+BANK_W+COL_W-1:0]  addr,
    input  logic                                  ref_req,
    output logic                                  busy,
    output logic                                  ref_done,
    output logic [(1<<RANK_W)-1:0]                sd_cs_n,
    output logic                                  sd_ras_n,
    output logic                                  sd_cas_n,
    output logic                                  sd_we_n,
    output logic [BANK_W-1:0]                     sd_ba,
    output logic [ROW_W-1:0]                      sd_a
);
    import rowseq_pkg::*;

    localparam int ADDR_W = RANK_W + ROW_W + BANK_W + COL_W;
    localparam int RANKS  = 1 << RANK_W;
    localparam int IDX_W  = RANK_W + BANK_W;
    localparam int NB     = 1 << IDX_W;
    localparam int RK_W   = (RANK_W > 0) ? RANK_W : 1;
    localparam int HALF   = BURST_LEN / 2;
    localparam int DW     = $clog2(HALF + 1);

    seq_state_e        state_q;
    logic [ADDR_W-1:0] req_q;
    logic              req_wr_q;
    logic [DW-1:0]     dcnt_q;

    logic [RK_W-1:0]   rank;
    logic [ROW_W-1:0]  row;
    logic [BANK_W-1:0] bank;
    logic [COL_W-1:0]  col;
    logic [IDX_W-1:0]  idx;

    logic open_v;
    logic [ROW_W-1:0] open_row;
    logic ok_act, ok_pre, ok_preall, ok_rd, ok_wr, trp_z;
    logic act_go, pre_go, col_go, preall_go;

    assign col  = req_q[COL_W-1:0];
    assign bank = req_q[COL_W +: BANK_W];
    assign row  = req_q[COL_W+BANK_W +: ROW_W];

    if (RANK_W > 0) begin : g_ranked
        assign rank = req_q[ADDR_W-1 -: RANK_W];
        assign idx  = {rank, bank};
    end else begin : g_single
        assign rank = '0;
        assign idx  = bank;
    end

    // column address with A10 left free for the auto-precharge flag
    function automatic logic [ROW_W-1:0] colmap(input logic [COL_W-1:0] c);
        logic [ROW_W-1:0] m;
        m = '0;
        for (int i = 0; i < COL_W; i++) begin
            if (i < 10) m[i] = c[i];
            else        m[i+1] = c[i];
        end
        return m;
    endfunction

    rowseq_table #(.NB(NB), .IDX_W(IDX_W), .ROW_W(ROW_W)) u_table (
        .clk(clk), .rst_n(rst_n), .idx(idx),
        .set(act_go), .set_row(row), .clr(pre_go), .clr_all(preall_go),
        .open_v(open_v), .open_row(open_row)
    );

    rowseq_timers #(.NB(NB), .IDX_W(IDX_W), .BURST_LEN(BURST_LEN),
                    .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS), .T_RC(T_RC),
                    .T_RRD(T_RRD), .T_WR(T_WR), .T_WTR(T_WTR)) u_timers (
        .clk(clk), .rst_n(rst_n), .idx(idx),
        .act_ld(act_go), .pre_ld(pre_go), .preall_ld(preall_go),
        .rd_ld(col_go && !req_wr_q), .wr_ld(col_go && req_wr_q),
        .ok_act(ok_act), .ok_pre(ok_pre), .ok_preall(ok_preall),
        .ok_rd(ok_rd), .ok_wr(ok_wr), .trp_z(trp_z)
    );

    // pick the next SDRAM command the pending request may issue now
    always_comb begin
        act_go    = 1'b0;
        pre_go    = 1'b0;
        col_go    = 1'b0;
        preall_go = 1'b0;
        if (state_q == S_WORK) begin
            if (open_v && open_row == row) col_go = req_wr_q ? ok_wr : ok_rd;
            else if (!open_v)              act_go = ok_act;
            else                           pre_go = ok_pre;
        end else if (state_q == S_RPRE) begin
            preall_go = ok_preall;
        end
    end

    assign busy = (state_q != S_IDLE);

    // sequencer state, request capture and registered pins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            req_q    <= '0;
            req_wr_q <= 1'b0;
            dcnt_q   <= '0;
            ref_done <= 1'b0;
            sd_cs_n  <= '1;
            {sd_ras_n, sd_cas_n, sd_we_n} <= PIN_NOP;
            sd_ba    <= '0;
            sd_a     <= '0;
        end else begin
            ref_done <= 1'b0;
            sd_cs_n  <= '1;
            {sd_ras_n, sd_cas_n, sd_we_n} <= PIN_NOP;
            case (state_q)
                S_IDLE: begin
                    if (ref_req) begin
                        state_q <= S_RPRE;
                    end else if (cmd == UC_READ || cmd == UC_WRITE) begin
                        req_q    <= addr;
                        req_wr_q <= (cmd == UC_WRITE);
                        state_q  <= S_WORK;
                    end
                end
                S_WORK: begin
                    if (act_go || pre_go || col_go) begin
                        sd_cs_n <= ~(RANKS'(1) << rank);
                        sd_ba   <= bank;
                    end
                    if (act_go) begin
                        {sd_ras_n, sd_cas_n, sd_we_n} <= PIN_ACT;
                        sd_a <= row;
                    end else if (pre_go) begin
                        {sd_ras_n, sd_cas_n, sd_we_n} <= PIN_PRE;
                        sd_a <= '0;
                    end else if (col_go) begin
                        {sd_ras_n, sd_cas_n, sd_we_n} <= req_wr_q ? PIN_WR : PIN_RD;
                        sd_a    <= colmap(col);
                        dcnt_q  <= DW'(HALF - 1);
                        state_q <= S_DATA;
                    end
                end
                S_DATA: begin
                    if (dcnt_q == '0) state_q <= S_IDLE;
                    else              dcnt_q  <= dcnt_q - 1'b1;
                end
                S_RPRE: begin
                    if (preall_go) begin
                        sd_cs_n <= '0;
                        {sd_ras_n, sd_cas_n, sd_we_n} <= PIN_PRE;
                        sd_a    <= ROW_W'(1) << 10;
                        state_q <= S_RWAIT;
                    end
                end
                S_RWAIT: begin
                    if (trp_z) begin
                        ref_done <= 1'b1;
                        state_q  <= S_IDLE;
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assert_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !ref_req && (cmd == UC_READ || cmd == UC_WRITE)) |=> busy);
    assert_idle_nop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> ({sd_ras_n, sd_cas_n, sd_we_n} == PIN_NOP && &sd_cs_n));
    assert_cs_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !({sd_ras_n, sd_cas_n, sd_we_n} == PIN_PRE && sd_a[10]) |-> $onehot0(~sd_cs_n));
    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ref_done |=> !ref_done);
endmodule

// File: tb/rowseq_top_tb.sv
`timescale 1ns/1ps
// Bench: directed corners plus seeded random traffic, checked by a pin
// monitor against timestamps and an open-row model kept in the bench.
module rowseq_top_tb_top;
    localparam int TRCD = 2, TRP = 2, TRAS = 6, TRC = 8, TRRD = 2, TWR = 2, TWTR = 1;
    localparam int HALF = 2;      // burst length 4
    localparam int NB   = 8;      // 2 ranks x 4 banks
    localparam int T_ACT = 0, T_RD = 1, T_WR = 2, T_PRE = 3, T_PALL = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cmd = 3'b000;
    logic [25:0] addr = '0;
    logic        ref_req = 1'b0;
    logic        busy, ref_done, ras_n, cas_n, we_n;
    logic [1:0]  cs_n, ba;
    logic [11:0] a;

    rowseq_top dut_i (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .addr(addr), .ref_req(ref_req),
        .busy(busy), .ref_done(ref_done), .sd_cs_n(cs_n), .sd_ras_n(ras_n),
        .sd_cas_n(cas_n), .sd_we_n(we_n), .sd_ba(ba), .sd_a(a)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0, n_fail = 0, cyc = 0;
    int obs_typ [8], obs_cs [8], obs_ba [8], obs_a [8], obs_t [8];
    int obs_n = 0;
    int done_t = -1, done_cnt = 0;
    int t_act [NB], t_pre [NB], t_wend [NB];
    int t_act_any = -1000, t_wend_any = -1000;
    bit m_v [NB];
    int m_row [NB];

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // pin monitor: samples 1 ns after each rising edge
    initial begin
        for (int i = 0; i < NB; i++) begin
            t_act[i] = -1000; t_pre[i] = -1000; t_wend[i] = -1000;
        end
        forever begin
            @(posedge clk); #1;
            cyc++;
            if (rst_n) begin
                int pins, ty, rk, ix;
                pins = {ras_n, cas_n, we_n};
                ty = -1;
                case (pins)
                    3'b011: ty = T_ACT;
                    3'b101: ty = T_RD;
                    3'b100: ty = T_WR;
                    3'b010: ty = a[10] ? T_PALL : T_PRE;
                    3'b111: ty = -1;
                    default: chk(1'b0, "R4 pin code", pins, 7);
                endcase
                if (ty < 0) begin
                    if (pins == 7 && cs_n != 2'b11) chk(1'b0, "R4 chip select on NOP", cs_n, 3);
                end else if (ty == T_PALL) begin
                    chk(cs_n == 2'b00, "R11 all chip selects", cs_n, 0);
                    for (int i = 0; i < NB; i++) begin
                        chk(cyc - t_act[i] >= TRAS, "R7 tRAS before precharge-all", cyc - t_act[i], TRAS);
                        chk(cyc - t_wend[i] >= TWR, "R9 tWR before precharge-all", cyc - t_wend[i], TWR);
                        t_pre[i] = cyc;
                    end
                end else begin
                    chk(cs_n == 2'b10 || cs_n == 2'b01, "R3 single chip select", cs_n, 2);
                    rk = (cs_n == 2'b10) ? 0 : 1;
                    ix = rk * 4 + int'(ba);
                    if (ty == T_ACT) begin
                        chk(cyc - t_act[ix] >= TRC, "R8 tRC same bank", cyc - t_act[ix], TRC);
                        chk(cyc - t_act_any >= TRRD, "R8 tRRD", cyc - t_act_any, TRRD);
                        chk(cyc - t_pre[ix] >= TRP, "R7 tRP", cyc - t_pre[ix], TRP);
                        t_act[ix] = cyc; t_act_any = cyc;
                    end else if (ty == T_PRE) begin
                        chk(cyc - t_act[ix] >= TRAS, "R7 tRAS", cyc - t_act[ix], TRAS);
                        chk(cyc - t_wend[ix] >= TWR, "R9 tWR", cyc - t_wend[ix], TWR);
                        t_pre[ix] = cyc;
                    end else begin
                        chk(cyc - t_act[ix] >= TRCD, "R6 tRCD", cyc - t_act[ix], TRCD);
                        if (ty == T_RD)
                            chk(cyc - t_wend_any >= TWTR, "R9 tWTR", cyc - t_wend_any, TWTR);
                        else begin
                            t_wend[ix] = cyc + HALF; t_wend_any = cyc + HALF;
                        end
                    end
                end
                if (ty >= 0 && obs_n < 8) begin
                    obs_typ[obs_n] = ty; obs_cs[obs_n] = int'(cs_n); obs_ba[obs_n] = int'(ba);
                    obs_a[obs_n] = int'(a); obs_t[obs_n] = cyc;
                    obs_n++;
                end
                if (ref_done) begin done_t = cyc; done_cnt++; end
            end
            if (cyc > 150000) begin
                chk(1'b0, "watchdog", cyc, 150000);
                finish_run();
            end
        end
    end

    task automatic wait_idle;
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    // one user access, compared with the sequence the model predicts
    task automatic do_access(input bit wr, input int rank, input int row, input int bank,
                             input int col, input bit timed, input bit ref_pulse);
        int ix, kind, nexp, acc, lo, dc, k, ecs;
        logic [10:0] c;
        logic [11:0] ecol;
        wait_idle();
        ix = rank * 4 + bank;
        kind = !m_v[ix] ? 1 : (m_row[ix] == row ? 0 : 2);
        nexp = (kind == 0) ? 1 : (kind == 1 ? 2 : 3);
        c = 11'(col);
        ecol = {c[10], 1'b0, c[9:0]};
        ecs = (rank == 0) ? 2 : 1;
        dc = done_cnt;
        obs_n = 0;
        cmd = wr ? 3'b010 : 3'b001;
        addr = {1'(rank), 12'(row), 2'(bank), c};
        @(negedge clk);
        cmd = 3'b000;
        acc = cyc;
        chk(busy == 1'b1, "R1 busy after accept", busy, 1);
        if (ref_pulse) begin
            ref_req = 1'b1;
            @(negedge clk);
            ref_req = 1'b0;
        end
        while (busy) @(negedge clk);
        lo = cyc;
        chk(obs_n == nexp, "R5 R6 R7 sequence length", obs_n, nexp);
        if (obs_n == nexp) begin
            k = 0;
            if (kind == 2) begin
                chk(obs_typ[0] == T_PRE, "R7 precharge first", obs_typ[0], T_PRE);
                k = 1;
            end
            if (kind != 0) begin
                chk(obs_typ[k] == T_ACT, "R6 activate", obs_typ[k], T_ACT);
                chk(obs_a[k] == row, "R3 row on address", obs_a[k], row);
                k++;
            end
            chk(obs_typ[k] == (wr ? T_WR : T_RD), "R4 column code", obs_typ[k], wr ? T_WR : T_RD);
            chk(obs_a[k] == int'(ecol), "R3 column mapping", obs_a[k], ecol);
            for (int i = 0; i < nexp; i++) begin
                chk(obs_cs[i] == ecs, "R3 chip select", obs_cs[i], ecs);
                chk(obs_ba[i] == bank, "R3 bank", obs_ba[i], bank);
            end
            chk(lo == obs_t[k] + HALF, "R2 busy through data phase", lo - obs_t[k], HALF);
            if (timed && kind == 0)
                chk(obs_t[0] == acc + 1, "R5 hit latency", obs_t[0] - acc, 1);
        end
        if (ref_pulse) chk(done_cnt == dc, "R12 refresh while busy ignored", done_cnt - dc, 0);
        m_v[ix] = 1'b1;
        m_row[ix] = row;
    endtask

    task automatic do_refresh(input bit with_cmd);
        int dc;
        wait_idle();
        dc = done_cnt;
        obs_n = 0;
        ref_req = 1'b1;
        if (with_cmd) begin cmd = 3'b001; addr = '0; end
        @(negedge clk);
        ref_req = 1'b0;
        cmd = 3'b000;
        while (busy) @(negedge clk);
        chk(obs_n == 1, "R11 single command", obs_n, 1);
        chk(obs_typ[0] == T_PALL, "R11 precharge-all", obs_typ[0], T_PALL);
        chk(done_cnt == dc + 1, "R11 one done pulse", done_cnt - dc, 1);
        chk(done_t == obs_t[0] + TRP, "R11 done after tRP", done_t - obs_t[0], TRP);
        @(negedge clk);
        chk(ref_done == 1'b0, "R11 done lasts one cycle", ref_done, 0);
        for (int i = 0; i < NB; i++) m_v[i] = 1'b0;
    endtask

    task automatic do_ignored(input logic [2:0] code);
        wait_idle();
        obs_n = 0;
        cmd = code;
        addr = 26'($urandom);
        @(negedge clk);
        cmd = 3'b000;
        chk(busy == 1'b0, "R1 ignored code keeps busy low", busy, 0);
        @(negedge clk);
        chk(obs_n == 0, "R1 ignored code drives no pins", obs_n, 0);
    endtask

    initial begin
        int r, s;
        for (int i = 0; i < NB; i++) begin m_v[i] = 1'b0; m_row[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0, "R4 reset busy", busy, 0);
        chk(ref_done == 1'b0, "R4 reset done", ref_done, 0);
        chk({ras_n, cas_n, we_n} == 3'b111, "R4 reset NOP", {ras_n, cas_n, we_n}, 7);
        chk(cs_n == 2'b11, "R4 reset chip selects", cs_n, 3);

        // directed corners
        do_ignored(3'b000);
        do_ignored(3'b011);
        do_ignored(3'b111);
        do_access(1'b0, 0, 5, 1, 12'h3ff, 1'b0, 1'b0);   // R6 closed bank
        do_access(1'b1, 1, 7, 1, 12'h400, 1'b0, 1'b0);   // R10 other rank, same bank
        repeat (20) @(negedge clk);
        do_access(1'b0, 0, 5, 1, 12'h7ff, 1'b1, 1'b0);   // R5 hit, R10 row kept
        do_access(1'b1, 0, 9, 1, 3, 1'b0, 1'b0);          // R7 miss right after use
        do_access(1'b0, 0, 9, 1, 4, 1'b0, 1'b0);          // R9 read after write
        do_access(1'b0, 0, 2, 1, 5, 1'b0, 1'b1);          // R9 tWR miss + R12 pulse
        do_access(1'b0, 1, 1, 2, 6, 1'b0, 1'b0);
        do_access(1'b0, 1, 1, 3, 6, 1'b0, 1'b0);          // R8 tRRD
        do_refresh(1'b0);
        do_access(1'b0, 0, 2, 1, 7, 1'b0, 1'b0);          // R11 closed after refresh
        do_refresh(1'b1);                                  // R11 request wins

        // seeded random traffic
        s = $urandom(32'h5eed);
        for (int n = 0; n < 400; n++) begin
            r = $urandom % 16;
            if (r == 0)      do_refresh(1'b0);
            else if (r == 1) do_ignored(3'(3 + $urandom % 5));
            else             do_access(1'($urandom), $urandom % 2, $urandom % 3,
                                       $urandom % 4, $urandom % 2048, 1'b0, r == 2);
        end
        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule